// File: doc/BRIEF.md
# Burst Address Sequencer with Ordering Mode

This block produces the word address presented to a synchronous burst memory. A new base address is captured whenever either of two address strobes is seen at a rising clock edge. One strobe belongs to the processor side and the other to the memory controller side. On later cycles an advance input steps the low-order burst offset through a four-word burst, while the upper address bits stay as they were loaded.

The offset follows one of two orders. Linear order adds the step count to the starting offset, modulo the burst length. Interleaved order XORs the step count into the starting offset. An ordering input picks the order at run time. When the design is built without that input (`ORDER_PIN_EN = 0`), the input is disregarded and interleaved order is always used. Interleaved order is also the order that applies with the input held low. A fresh address may be loaded on every cycle, so a burst can be abandoned at any point without a lost cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: When `strb_ctl_i` is high, or when `strb_cpu_i` is high with `sel_ok_i` high, at a rising edge, `addr_o` equals the sampled `addr_i` after that edge.
- R2: While `sel_ok_i` is low, `strb_cpu_i` has no effect: `addr_o` holds, or steps if `adv_i` is high. `strb_ctl_i` still loads while `sel_ok_i` is low.
- R3: A qualifying strobe takes priority over `adv_i`. When both strobes are high, the address is loaded.
- R4: With no load, `addr_o` steps only at edges where `adv_i` is high, and is otherwise unchanged.
- R5: With `order_lin_i` = 1, the low `BURST_W` bits after n advances equal (start + n) mod 2^BURST_W.
- R6: With `order_lin_i` = 0, the low `BURST_W` bits after n advances equal start XOR (n mod 2^BURST_W).
- R7: With `ORDER_PIN_EN` = 0, the sequence is interleaved (as in R6) whatever the value of `order_lin_i`.
- R8: During a burst, bits above the low `BURST_W` keep the value that was loaded.
- R9: After 2^BURST_W advances (four when BURST_W = 2), the offset returns to the starting offset and keeps cycling.
- R10: While `rst_n` is low, and directly after reset, `addr_o` is all zeros.
- R11: Loads on consecutive cycles are each reflected in `addr_o` one edge later, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | External address captured on a load |
| strb_cpu_i | input | 1 | Processor-side address strobe; acts only when selected |
| strb_ctl_i | input | 1 | Controller-side address strobe; always loads |
| adv_i | input | 1 | Burst advance |
| sel_ok_i | input | 1 | Chip-selected qualifier for the processor-side strobe |
| order_lin_i | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_o | output | ADDR_W | Registered current word address |

## Verification
The assertions assume that `order_lin_i` holds steady from a load until the next load. Under that assumption, the interleaved check can follow a start offset and step count from the most recent load, and the linear check can compare each step with the previous offset plus one. The bench changes the ordering input only in the same cycle as a strobe. It sweeps every starting offset in both orders with both strobes, runs past the wrap point, and inserts hold cycles inside bursts.

// File: rtl/bas_pkg.sv
package bas_pkg;

   typedef enum logic {
      ORD_ILV = 1'b0,
      ORD_LIN = 1'b1
   } order_e;

   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_LOAD = 2'd1,
      ACT_STEP = 2'd2
   } act_e;

endpackage

// File: rtl/bas_load_ctl.sv
module bas_load_ctl
   import bas_pkg::*;
(
   input  logic strb_cpu_i,
   input  logic strb_ctl_i,
   input  logic adv_i,
   input  logic sel_ok_i,
   output act_e act_o
);

   logic cpu_qual;

   assign cpu_qual = strb_cpu_i & sel_ok_i;

   always_comb begin
      if (strb_ctl_i || cpu_qual) begin
         act_o = ACT_LOAD;
      end else if (adv_i) begin
         act_o = ACT_STEP;
      end else begin
         act_o = ACT_HOLD;
      end
   end

endmodule

// File: rtl/bas_burst_cnt.sv
module bas_burst_cnt
   import bas_pkg::*;
#(
   parameter int BURST_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  act_e               act_i,
   output logic [BURST_W-1:0] idx_inc_o
);

   logic [BURST_W-1:0] idx_q;

   assign idx_inc_o = idx_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else begin
         unique case (act_i)
            ACT_LOAD: idx_q <= '0;
            ACT_STEP: idx_q <= idx_inc_o;
            default:  idx_q <= idx_q;
         endcase
      end
   end

endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
   import bas_pkg::*;
#(
   parameter int BURST_W      = 2,
   parameter bit ORDER_PIN_EN = 1'b1
) (
   input  logic [BURST_W-1:0] start_i,
   input  logic [BURST_W-1:0] idx_i,
   input  logic               order_lin_i,
   output logic [BURST_W-1:0] off_o
);

   order_e mode;

   generate
      if (ORDER_PIN_EN) begin : g_pin
         assign mode = order_lin_i ? ORD_LIN : ORD_ILV;
      end else begin : g_fixed
         logic unused_pin;
         assign unused_pin = order_lin_i;
         assign mode = ORD_ILV;
      end
   endgenerate

   always_comb begin
      if (mode == ORD_LIN) begin
         off_o = start_i + idx_i;
      end else begin
         off_o = start_i ^ idx_i;
      end
   end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import bas_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int BURST_W      = 2,
   parameter bit ORDER_PIN_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              strb_cpu_i,
   input  logic              strb_ctl_i,
   input  logic              adv_i,
   input  logic              sel_ok_i,
   input  logic              order_lin_i,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int HI_W = ADDR_W - BURST_W;

   generate
      if (BURST_W < 1) begin : g_bad_burst
         $error("BURST_W must be at least 1");
      end
      if (HI_W < 1) begin : g_bad_addr
         $error("ADDR_W must exceed BURST_W");
      end
   endgenerate

   act_e               act;
   logic [BURST_W-1:0] idx_inc;
   logic [BURST_W-1:0] base_lo_q;
   logic [BURST_W-1:0] next_off;
   logic [ADDR_W-1:0]  addr_q;

   bas_load_ctl u_ctl (
      .strb_cpu_i (strb_cpu_i),
      .strb_ctl_i (strb_ctl_i),
      .adv_i      (adv_i),
      .sel_ok_i   (sel_ok_i),
      .act_o      (act)
   );

   bas_burst_cnt #(.BURST_W(BURST_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_i     (act),
      .idx_inc_o (idx_inc)
   );

   bas_order_map #(.BURST_W(BURST_W), .ORDER_PIN_EN(ORDER_PIN_EN)) u_map (
      .start_i     (base_lo_q),
      .idx_i       (idx_inc),
      .order_lin_i (order_lin_i),
      .off_o       (next_off)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q    <= '0;
         base_lo_q <= '0;
      end else begin
         unique case (act)
            ACT_LOAD: begin
               addr_q    <= addr_i;
               base_lo_q <= addr_i[BURST_W-1:0];
            end
            ACT_STEP: begin
               addr_q[BURST_W-1:0] <= next_off;
            end
            default: begin
               addr_q <= addr_q;
            end
         endcase
      end
   end

   assign addr_o = addr_q;

endmodule

// File: rtl/bas_checker.sv
module bas_checker #(
   parameter int ADDR_W       = 20,
   parameter int BURST_W      = 2,
   parameter bit ORDER_PIN_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr_i,
   input logic              strb_cpu_i,
   input logic              strb_ctl_i,
   input logic              adv_i,
   input logic              sel_ok_i,
   input logic              order_lin_i,
   input logic [ADDR_W-1:0] addr_o
);

   logic               ld;
   logic               lin_eff;
   logic [BURST_W-1:0] lo_now;
   logic [BURST_W-1:0] lo_inc;
   logic [BURST_W-1:0] m_start;
   logic [BURST_W-1:0] m_n;
   logic [BURST_W-1:0] m_off;

   assign ld      = strb_ctl_i | (strb_cpu_i & sel_ok_i);
   assign lin_eff = ORDER_PIN_EN ? order_lin_i : 1'b0;
   assign lo_now  = addr_o[BURST_W-1:0];
   assign lo_inc  = lo_now + 1'b1;
   assign m_off   = m_start ^ m_n;

   // Reference tracking of the burst start and step count since the last load
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_start <= '0;
         m_n     <= '0;
      end else if (ld) begin
         m_start <= addr_i[BURST_W-1:0];
         m_n     <= '0;
      end else if (adv_i) begin
         m_n     <= m_n + 1'b1;
      end
   end

   p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> addr_o == $past(addr_i));

   p_desel_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (strb_cpu_i && !sel_ok_i && !strb_ctl_i && !adv_i) |=> $stable(addr_o));

   p_strobe_over_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (strb_cpu_i && sel_ok_i && adv_i) |=> addr_o == $past(addr_i));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !adv_i) |=> $stable(addr_o));

   p_linear_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && adv_i && lin_eff) |=> lo_now == $past(lo_inc));

   p_interleave_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && adv_i && !lin_eff) |=> lo_now == m_off);

   p_upper_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> addr_o[ADDR_W-1:BURST_W] == $past(addr_o[ADDR_W-1:BURST_W]));

endmodule

bind burst_addr_seq bas_checker #(
   .ADDR_W       (ADDR_W),
   .BURST_W      (BURST_W),
   .ORDER_PIN_EN (ORDER_PIN_EN)
) u_bas_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .addr_i      (addr_i),
   .strb_cpu_i  (strb_cpu_i),
   .strb_ctl_i  (strb_ctl_i),
   .adv_i       (adv_i),
   .sel_ok_i    (sel_ok_i),
   .order_lin_i (order_lin_i),
   .addr_o      (addr_o)
);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;

   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr_i;
   logic          strb_cpu_i, strb_ctl_i, adv_i, sel_ok_i, order_lin_i;
   logic [AW-1:0] addr_o;
   logic [AW-1:0] addr_fix_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   burst_addr_seq #(.ADDR_W(AW), .BURST_W(2), .ORDER_PIN_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .strb_cpu_i(strb_cpu_i),
      .strb_ctl_i(strb_ctl_i), .adv_i(adv_i), .sel_ok_i(sel_ok_i),
      .order_lin_i(order_lin_i), .addr_o(addr_o)
   );

   burst_addr_seq #(.ADDR_W(AW), .BURST_W(2), .ORDER_PIN_EN(1'b0)) dut_fix_i (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .strb_cpu_i(strb_cpu_i),
      .strb_ctl_i(strb_ctl_i), .adv_i(adv_i), .sel_ok_i(sel_ok_i),
      .order_lin_i(order_lin_i), .addr_o(addr_fix_o)
   );

   function automatic logic [1:0] exp_off(input logic [1:0] s, input int n, input logic lin);
      logic [1:0] nn;
      nn = 2'(n);
      return lin ? 2'(s + nn) : (s ^ nn);
   endfunction

   task automatic check(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic drive(input logic [AW-1:0] a, input logic cpu, input logic ctl,
                        input logic adv, input logic sel, input logic lin);
      addr_i = a; strb_cpu_i = cpu; strb_ctl_i = ctl;
      adv_i = adv; sel_ok_i = sel; order_lin_i = lin;
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [AW-1:0] base, held;
      rst_n = 1'b0;
      drive('1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
      tick; tick;
      check("R10 reset", addr_o, '0);
      check("R10 reset fixed", addr_fix_o, '0);
      drive('0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      rst_n = 1'b1;
      tick;
      check("R10 after reset", addr_o, '0);

      // Sweep both orders, every start offset, both strobes, across the wrap
      for (int lin = 0; lin < 2; lin++) begin
         for (int s = 0; s < 4; s++) begin
            for (int uc = 0; uc < 2; uc++) begin
               base = AW'((s * 37 + lin * 100 + uc * 11) & 8'hFC) | AW'(s);
               drive(base, 1'(!uc), 1'(uc), 1'b0, 1'b1, 1'(lin));
               tick;
               check("R1 load", addr_o, base);
               check("R1 load fixed", addr_fix_o, base);
               for (int n = 1; n <= 6; n++) begin
                  drive(~base, 1'b0, 1'b0, 1'b1, 1'b1, 1'(lin));
                  tick;
                  check(lin ? "R5 linear step" : "R6 interleaved step", addr_o,
                        {base[AW-1:2], exp_off(2'(s), n, 1'(lin))});
                  check("R7 fixed interleaved", addr_fix_o,
                        {base[AW-1:2], exp_off(2'(s), n, 1'b0)});
                  check("R8 upper kept", {addr_o[AW-1:2], 2'b00}, {base[AW-1:2], 2'b00});
                  if (n == 4) check("R9 wrap to start", addr_o, base);
                  if (n == 2) begin
                     held = addr_o;
                     drive(~base, 1'b0, 1'b0, 1'b0, 1'b1, 1'(lin));
                     tick;
                     check("R4 hold without advance", addr_o, held);
                  end
               end
            end
         end
      end

      // R2: processor strobe while deselected
      drive(8'h5A, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
      tick;
      drive(8'hC3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      tick;
      check("R2 deselected strobe ignored", addr_o, 8'h5A);
      drive(8'hC3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      tick;
      check("R2 deselected strobe, advance steps", addr_o, 8'h5B);
      drive(8'hC3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      tick;
      check("R2 controller strobe loads deselected", addr_o, 8'hC3);

      // R3: strobe priority over advance, both strobes together
      drive(8'h26, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
      tick;
      check("R3 strobe beats advance", addr_o, 8'h26);
      drive(8'h91, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
      tick;
      check("R3 both strobes load", addr_o, 8'h91);

      // R11: a new address on every cycle
      for (int k = 0; k < 8; k++) begin
         base = AW'(k * 29 + 3);
         drive(base, 1'(k % 2), 1'((k + 1) % 2), 1'b1, 1'b1, 1'(k % 3 == 0));
         tick;
         check("R11 back-to-back load", addr_o, base);
      end

      drive('0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      tick;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule